// File: doc/BRIEF.md
# Recirculating Serial Storage Controller

This block presents a bank of circulating serial storage loops to a processor as a byte-addressed memory. Every loop moves one bit per shift period. On each shift, a loop either takes a fresh bit or feeds its outgoing bit straight back in, so it keeps its contents with no refresh traffic. The loops are grouped into banks, and each bank is one byte wide. All loops share a single position counter that names the bit currently at the access point.

The processor raises a request with an address, a direction and, for a write, a data byte. The controller latches the request and holds `rdy_o` low. When the position counter reaches the requested position, it reads the byte or replaces it, then pulses `rdy_o` for one cycle. The wait therefore depends on where the loops are in their rotation. Each loop is enabled only when both its row select and its column select are active, so the banks form a grid.

Shifting uses two non-overlapping phases. On the first phase a one-bit front stage per loop is loaded. On the second phase the loop moves. One shift period is `2*(PHASE_GAP+1)` clock cycles.

Top module: `recirc_sr_mem`

## Requirements
- R1: After synchronous reset, `rdy_o` is low, `rdata_o` is zero and the position counter is 0. `rdy_o` never rises when no request is pending.
- R2: A read of an address returns the byte last written there. Address bits [8:0] give the bit position and bits [10:9] give the bank.
- R3: A write replaces only the addressed byte. Every other position keeps its contents across rotations, including positions 0 and 511 at the counter's wrap point.
- R4: Bank b sits at grid row b/2 and column b%2. A loop is written or read only when both its row select and its column select are active. Bytes at the same position in different banks are independent.
- R5: Each accepted request produces exactly one `rdy_o` pulse, one cycle long. For a read, `rdata_o` is valid in that same cycle.
- R6: The two shift phases are never active in the same cycle. The counter advances one position per 4-cycle shift period and wraps from 511 to 0. Two back-to-back accesses to the same address complete exactly 2048 cycles apart. No access completes later than 2052 cycles after it is accepted.
- R7: A request raised while another is still pending has no effect on storage or on the pending access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request strobe. It is taken only when no access is pending. |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 11 | {bank[1:0], position[8:0]} |
| wdata_i | input | 8 | Write byte |
| rdy_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read byte, valid with `rdy_o` |

## Verification
The embedded assertions check the per-cycle invariants:
- the two phases never overlap;
- the counter advances only on the second phase and wraps at 511;
- storage is frozen outside the shift phase;
- row and column selects are one-hot or idle;
- a pending address stays fixed until it completes;
- `rdy_o` is a single-cycle pulse raised only after the counter held the requested position;
- no wait exceeds one rotation plus a period.

Only the bench scenarios can show the data-carrying properties:
- bytes survive many rotations;
- neighbours and other banks are left untouched;
- a request injected during a wait is dropped;
- repeated accesses are spaced by exactly one full rotation.

// File: rtl/srm_pkg.sv
// Package srm_pkg
// Shared types for the recirculating serial storage controller.
// Assumes: used by every module of the block; holds no logic.
package srm_pkg;

    // Access controller state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } srm_state_e;

endpackage

// File: rtl/srm_phase_gen.sv
// Module srm_phase_gen
// Produces two non-overlapping one-cycle shift phases per period.
// Period = 2*(PHASE_GAP+1) cycles.
// phi1 (front-stage load) comes at count 0.
// phi2 (loop move) comes at count PHASE_GAP+1.
// Assumes: PHASE_GAP >= 0.
module srm_phase_gen #(
    parameter int PHASE_GAP = 1,
    localparam int PERIOD   = 2 * (PHASE_GAP + 1),
    localparam int CNT_W    = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic phi1,
    output logic phi2
);

    logic [CNT_W-1:0] ph_cnt;

    // Free-running phase counter, wraps at PERIOD-1.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 ph_cnt <= '0;
        else if (ph_cnt == CNT_W'(PERIOD - 1))      ph_cnt <= '0;
        else                                        ph_cnt <= ph_cnt + 1'b1;
    end

    // Phase decode.
    always_comb begin
        phi1 = rst_n && (ph_cnt == '0);
        phi2 = rst_n && (ph_cnt == CNT_W'(PHASE_GAP + 1));
    end

    // R6: phases never active together
    a_r6_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(phi1 && phi2));
    // R6: each phase lasts exactly one cycle
    a_r6_phi1_single: assert property (@(posedge clk) disable iff (!rst_n)
        phi1 |=> !phi1);

endmodule

// File: rtl/srm_pos_counter.sv
// Module srm_pos_counter
// Tracks which bit position sits at the loops' access point.
// Advances once per phi2 and wraps from LEN-1 to 0.
// Assumes: every loop moves on the same phi2.
module srm_pos_counter #(
    parameter int LEN   = 512,
    localparam int POS_W = $clog2(LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phi2,
    output logic [POS_W-1:0] pos
);

    // Step the position on every loop move.
    always_ff @(posedge clk) begin
        if (!rst_n)                              pos <= '0;
        else if (phi2 && pos == POS_W'(LEN - 1)) pos <= '0;
        else if (phi2)                           pos <= pos + 1'b1;
    end

    // R1: counter starts at 0 after reset
    a_r1_pos_reset: assert property (@(posedge clk)
        !rst_n |=> (pos == '0));
    // R6: counter holds between shift phases
    a_r6_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2 |=> $stable(pos));
    // R6: counter wraps from the last position to 0
    a_r6_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2 && pos == POS_W'(LEN - 1)) |=> (pos == '0));

endmodule

// File: rtl/srm_sreg.sv
// Module srm_sreg
// One circulating serial storage loop of LEN bits.
// phi1 loads a one-bit front stage: a new bit when written, else the outgoing bit.
// phi2 moves the loop by one place.
// Output is driven only while both selects are active.
// Assumes: LEN >= 2; phi1 and phi2 never overlap.
//          Storage has no reset, as in a real memory.
module srm_sreg #(
    parameter int LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phi1,
    input  logic phi2,
    input  logic sel_row,
    input  logic sel_col,
    input  logic wr_en,
    input  logic din,
    output logic dout
);

    logic [LEN-1:0] store;
    logic           front;
    logic           picked;

    assign picked = sel_row && sel_col;

    // Front stage: write a new bit or recirculate the outgoing one.
    always_ff @(posedge clk) begin
        if (!rst_n)     front <= 1'b0;
        else if (phi1)  front <= (picked && wr_en) ? din : store[LEN-1];
    end

    // Loop move on phi2.
    always_ff @(posedge clk) begin
        if (phi2) store <= {store[LEN-2:0], front};
    end

    // Gated output, active only when both selects are on.
    assign dout = picked ? store[LEN-1] : 1'b0;

    // R3: storage changes only in the move phase
    a_r3_store_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2 |=> $stable(store));

endmodule

// File: rtl/srm_access_ctrl.sv
// Module srm_access_ctrl
// Latches one request and waits until the counter shows the requested position on phi1.
// It then performs the access and pulses rdy_o once.
// Requests arriving while one is pending are dropped.
// Assumes: cur_pos and phi1 come from the shared counter and phase generator.
module srm_access_ctrl
    import srm_pkg::*;
#(
    parameter int LEN       = 512,
    parameter int WORD_W    = 8,
    parameter int GRID_ROWS = 2,
    parameter int GRID_COLS = 2,
    parameter int PERIOD    = 4,
    localparam int POS_W    = $clog2(LEN),
    localparam int BANKS    = GRID_ROWS * GRID_COLS,
    localparam int BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int ADDR_W   = POS_W + BANK_W,
    localparam int LIMIT    = (LEN + 1) * PERIOD,
    localparam int WAIT_W   = $clog2(LIMIT + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic                 we_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [WORD_W-1:0]    wdata_i,
    input  logic                 phi1,
    input  logic [POS_W-1:0]     cur_pos,
    input  logic [WORD_W-1:0]    rd_word,
    output logic [GRID_ROWS-1:0] row_cs,
    output logic [GRID_COLS-1:0] col_cs,
    output logic                 wr_strobe,
    output logic [WORD_W-1:0]    wdata_l,
    output logic                 rdy_o,
    output logic [WORD_W-1:0]    rdata_o
);

    srm_state_e        state;
    logic [POS_W-1:0]  pos_l;
    logic [BANK_W-1:0] bank_l;
    logic              we_l;
    logic              accept;
    logic              hit;
    logic [WAIT_W-1:0] wait_cnt;

    assign accept    = (state == ST_IDLE) && req_i;
    assign hit       = (state == ST_WAIT) && phi1 && (cur_pos == pos_l);
    assign wr_strobe = hit && we_l;

    // Request latch, completion and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pos_l   <= '0;
            bank_l  <= '0;
            we_l    <= 1'b0;
            wdata_l <= '0;
            rdy_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            rdy_o <= hit;
            if (accept) begin
                state   <= ST_WAIT;
                pos_l   <= addr_i[POS_W-1:0];
                bank_l  <= addr_i[ADDR_W-1:POS_W];
                we_l    <= we_i;
                wdata_l <= wdata_i;
            end else if (hit) begin
                state <= ST_IDLE;
                if (!we_l) rdata_o <= rd_word;
            end
        end
    end

    // Grid decode of the latched bank: row = bank / cols, col = bank % cols.
    always_comb begin
        for (int r = 0; r < GRID_ROWS; r++)
            row_cs[r] = (state == ST_WAIT) && (int'(bank_l) / GRID_COLS == r);
        for (int c = 0; c < GRID_COLS; c++)
            col_cs[c] = (state == ST_WAIT) && (int'(bank_l) % GRID_COLS == c);
    end

    // Cycles spent waiting, used by the bound check.
    always_ff @(posedge clk) begin
        if (!rst_n || accept)      wait_cnt <= '0;
        else if (state == ST_WAIT) wait_cnt <= wait_cnt + 1'b1;
    end

    // R1: no ready and no pending access right after reset
    a_r1_idle_reset: assert property (@(posedge clk)
        !rst_n |=> (!rdy_o && state == ST_IDLE));
    // R5: ready is a one-cycle pulse
    a_r5_rdy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |=> !rdy_o);
    // R2: completion only after the requested position was at the access point
    a_r2_hit_pos: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> ($past(cur_pos) == pos_l && $past(phi1)));
    // R4: at most one row and one column selected
    a_r4_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_cs) && $onehot0(col_cs));
    // R7: a pending access is not disturbed by new requests
    a_r7_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !hit) |=>
            (state == ST_WAIT && $stable(pos_l) && $stable(bank_l) && $stable(we_l)));
    // R6: wait never exceeds one rotation plus one period
    a_r6_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (int'(wait_cnt) <= LIMIT));

endmodule

// File: rtl/recirc_sr_mem.sv
// Module recirc_sr_mem
// Top level: a grid of circulating byte-wide banks behind a request/ready port.
// Contains the phase generator, the shared position counter, the access controller
// and BANKS*WORD_W storage loops.
// Assumes: one request at a time; req_i is taken only when idle.
module recirc_sr_mem #(
    parameter int REG_BITS  = 512,
    parameter int WORD_W    = 8,
    parameter int GRID_ROWS = 2,
    parameter int GRID_COLS = 2,
    parameter int PHASE_GAP = 1,
    localparam int POS_W    = $clog2(REG_BITS),
    localparam int BANKS    = GRID_ROWS * GRID_COLS,
    localparam int BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int ADDR_W   = POS_W + BANK_W,
    localparam int PERIOD   = 2 * (PHASE_GAP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic              rdy_o,
    output logic [WORD_W-1:0] rdata_o
);

    logic                         phi1;
    logic                         phi2;
    logic [POS_W-1:0]             cur_pos;
    logic [GRID_ROWS-1:0]         row_cs;
    logic [GRID_COLS-1:0]         col_cs;
    logic                         wr_strobe;
    logic [WORD_W-1:0]            wdata_l;
    logic [BANKS-1:0][WORD_W-1:0] bank_out;
    logic [WORD_W-1:0]            rd_word;

    srm_phase_gen #(.PHASE_GAP(PHASE_GAP)) u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .phi1 (phi1),
        .phi2 (phi2)
    );

    srm_pos_counter #(.LEN(REG_BITS)) u_pos (
        .clk  (clk),
        .rst_n(rst_n),
        .phi2 (phi2),
        .pos  (cur_pos)
    );

    srm_access_ctrl #(
        .LEN      (REG_BITS),
        .WORD_W   (WORD_W),
        .GRID_ROWS(GRID_ROWS),
        .GRID_COLS(GRID_COLS),
        .PERIOD   (PERIOD)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .we_i     (we_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .phi1     (phi1),
        .cur_pos  (cur_pos),
        .rd_word  (rd_word),
        .row_cs   (row_cs),
        .col_cs   (col_cs),
        .wr_strobe(wr_strobe),
        .wdata_l  (wdata_l),
        .rdy_o    (rdy_o),
        .rdata_o  (rdata_o)
    );

    // Storage grid: bank b takes row b/GRID_COLS and column b%GRID_COLS.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        for (genvar w = 0; w < WORD_W; w++) begin : g_bit
            srm_sreg #(.LEN(REG_BITS)) u_loop (
                .clk    (clk),
                .rst_n  (rst_n),
                .phi1   (phi1),
                .phi2   (phi2),
                .sel_row(row_cs[b / GRID_COLS]),
                .sel_col(col_cs[b % GRID_COLS]),
                .wr_en  (wr_strobe),
                .din    (wdata_l[w]),
                .dout   (bank_out[b][w])
            );
        end
    end

    // Merge gated bank outputs; only the selected bank drives non-zero.
    always_comb begin
        rd_word = '0;
        for (int b = 0; b < BANKS; b++) rd_word = rd_word | bank_out[b];
    end

endmodule

// File: tb/recirc_sr_mem_tb.sv
// Scoreboard bench for recirc_sr_mem.
// The driver pushes expected results; the monitor pops them on every rdy_o pulse.
module recirc_sr_mem_tb;

    localparam int LEN    = 512;
    localparam int PERIOD = 4;
    localparam int LIMIT  = (LEN + 1) * PERIOD + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic [10:0] addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic        rdy_o;
    logic [7:0]  rdata_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_rdy_cyc = 0;
    int prev_rdy_cyc = 0;
    bit prev_rdy = 1'b0;

    logic [8:0]  exp_q[$];
    string       tag_q[$];
    logic [7:0]  model [int];

    recirc_sr_mem u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .we_i   (we_i),
        .addr_i (addr_i),
        .wdata_i(wdata_i),
        .rdy_o  (rdy_o),
        .rdata_o(rdata_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops the scoreboard at each ready pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rdy_o) begin
                prev_rdy_cyc = last_rdy_cyc;
                last_rdy_cyc = cyc;
                checks++;
                if (prev_rdy) begin
                    fails++;
                    $display("FAIL R5: rdy_o high two cycles running, got 1 expected 0");
                end
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R1: rdy_o with no request pending, got 1 expected 0");
                end else begin
                    logic [8:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (e[8]) begin
                        checks++;
                        if (rdata_o !== e[7:0]) begin
                            fails++;
                            $display("FAIL %s: rdata_o got %02h expected %02h", t, rdata_o, e[7:0]);
                        end
                    end
                end
            end
            prev_rdy = rdy_o;
        end
    end

    // Driver: one access, with an optional injected request while it waits.
    task automatic access(input bit w, input int a, input logic [7:0] d, input string tag,
                          input bit intrude, input int ia, input logic [7:0] idata);
        int waited;
        if (w) begin
            exp_q.push_back({1'b0, 8'h00});
            model[a] = d;
        end else begin
            exp_q.push_back({1'b1, model.exists(a) ? model[a] : 8'h00});
        end
        tag_q.push_back(tag);
        req_i = 1'b1; we_i = w; addr_i = 11'(a); wdata_i = d;
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
        waited = 1;
        while (!rdy_o && waited < LIMIT) begin
            if (intrude && waited == 2) begin
                req_i = 1'b1; we_i = 1'b1; addr_i = 11'(ia); wdata_i = idata;
                @(negedge clk);
                req_i = 1'b0; we_i = 1'b0;
            end else begin
                @(negedge clk);
            end
            waited++;
        end
        checks++;
        if (!rdy_o) begin
            fails++;
            $display("FAIL R6: no completion within %0d cycles, got rdy_o=0 expected 1", LIMIT);
        end
    endtask

    // Watchdog: counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (rdy_o !== 1'b0) begin
            fails++; $display("FAIL R1: rdy_o got %b expected 0", rdy_o);
        end
        checks++;
        if (rdata_o !== 8'h00) begin
            fails++; $display("FAIL R1: rdata_o got %02h expected 00", rdata_o);
        end
        repeat (20) @(negedge clk);   // idle: monitor flags any spurious ready (R1)

        // R2/R3: writes, including both ends of the rotation
        access(1, 0,   8'h5A, "R2", 0, 0, 0);
        access(1, 511, 8'hC3, "R3", 0, 0, 0);
        access(1, 1,   8'h11, "R3", 0, 0, 0);
        // R4: same position in every bank
        for (int b = 0; b < 4; b++) access(1, b * 512 + 100, 8'hA0 + 8'(b), "R4", 0, 0, 0);
        // R7: inject a write to addr 100 while a write to 1500 waits
        access(1, 1500, 8'h7E, "R7", 1, 100, 8'hFF);

        access(0, 0,    8'h00, "R2", 0, 0, 0);
        access(0, 511,  8'h00, "R3", 0, 0, 0);
        access(0, 1,    8'h00, "R3", 0, 0, 0);
        access(0, 100,  8'h00, "R7", 0, 0, 0);
        access(0, 612,  8'h00, "R4", 0, 0, 0);
        access(0, 1124, 8'h00, "R4", 0, 0, 0);
        access(0, 1636, 8'h00, "R4", 0, 0, 0);
        access(0, 1500, 8'h00, "R2", 0, 0, 0);

        // R3: overwrite one byte, neighbours keep theirs
        access(1, 1, 8'h22, "R3", 0, 0, 0);
        access(0, 0, 8'h00, "R3", 0, 0, 0);
        access(0, 1, 8'h00, "R3", 0, 0, 0);
        access(0, 612, 8'h00, "R4", 0, 0, 0);

        // R6: back-to-back reads of one address are one rotation apart
        access(0, 511, 8'h00, "R6", 0, 0, 0);
        access(0, 511, 8'h00, "R6", 0, 0, 0);
        @(negedge clk);
        checks++;
        if (last_rdy_cyc - prev_rdy_cyc != LEN * PERIOD) begin
            fails++;
            $display("FAIL R6: completion spacing got %0d expected %0d",
                     last_rdy_cyc - prev_rdy_cyc, LEN * PERIOD);
        end
        repeat (10) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R5: outstanding results got %0d expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule